// File: doc/BRIEF.md
# ADC Start-Up Settling Gate

This block sits after a two-channel ADC datapath and hides the samples it produces while it settles after power-up. It watches four per-channel power-enable bits. When any one of them goes from off to on, it starts a settling window that is measured in sample periods. Throughout that window, both output channels carry two's-complement zero in place of the converter data. When the window closes, the real samples pass through again. A digital-microphone path that shares this stage gets the same window and the same zero-forcing.

A select input chooses between two window lengths: 1059 sample periods when it is low and 267 when it is high. Low, the long window, is the intended default. The select is captured at the edge that starts the window. A sample period is one pulse of a single-clock sample strobe. A busy output stays high from the starting edge until the last zeroed sample has reached the outputs.

Top module: `adc_settle_gate`

## Requirements
- R1: While reset is asserted and after it is released, busy is low and both outputs are zero until the first sample strobe.
- R2: A 0-to-1 change on any of the four enable bits, bit 0 through bit 3, sets busy on the next clock edge.
- R3: An enable bit that falls or stays constant starts no window. Busy stays low, and samples keep passing through.
- R4: With the select low at the starting edge, exactly 1059 sample strobes are zeroed.
- R5: With the select high at the starting edge, exactly 267 sample strobes are zeroed.
- R6: Changing the select while a window runs has no effect on the length of that window.
- R7: For each strobe taken while busy is high, both outputs become 0 on the clock edge after the strobe.
- R8: For each strobe taken while busy is low, each output takes that strobe's input sample on the next clock edge and holds it until the next strobe.
- R9: Busy falls on the same clock edge that loads the last zeroed sample into the outputs.
- R10: A new rising enable bit during a running window restarts it. The full length is then counted again from that edge, using the select value at that edge.
- R11: A strobe in the same clock as a starting edge, while busy is still low, passes its data and is not counted in the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwr_en | input | 4 | Per-channel power-enable bits |
| short_sel | input | 1 | Window length select: 0 gives 1059, 1 gives 267 sample periods |
| smp_stb | input | 1 | One-clock sample strobe |
| smp_l | input | 24 | Left raw sample, two's complement |
| smp_r | input | 24 | Right raw sample, two's complement |
| out_l | output | 24 | Left gated sample |
| out_r | output | 24 | Right gated sample |
| busy | output | 1 | Settling window active |

## Verification
On every cycle, the assertions check the following. Busy rises after any rising enable bit. A strobe taken while busy zeroes both outputs, and a strobe taken while idle passes its data. Busy only falls just after a strobe. A window never runs past the long length. Only the bench's scenarios can show the exact zeroed-sample counts for each select value. The same holds for ignoring the select during a window, restarting on a second edge, and the strobe that coincides with the starting edge.

// File: rtl/adc_settle_pkg.sv
package adc_settle_pkg;
  localparam int SMP_W = 24;

  typedef struct packed {
    logic [SMP_W-1:0] l;
    logic [SMP_W-1:0] r;
  } stereo_t;
endpackage

// File: rtl/en_rise_detect.sv
module en_rise_detect #(
  parameter int N_EN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EN-1:0] en,
  output logic            rise
);
  logic [N_EN-1:0] en_q;
  logic [N_EN-1:0] hit;

  for (genvar g = 0; g < N_EN; g++) begin : g_bit
    assign hit[g] = en[g] & ~en_q[g];
  end

  assign rise = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en;
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int LONG_CYC  = 1059,
  parameter int SHORT_CYC = 267
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic short_sel,
  input  logic stb,
  output logic busy
);
  localparam int CNT_W = $clog2(LONG_CYC + 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic             busy_q, busy_d;
  logic             upd;

  assign upd = start | (busy_q & stb);

  always_comb begin
    cnt_d  = cnt_q;
    last_d = last_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      last_d = short_sel ? SHORT_LAST : LONG_LAST;
    end else if (busy_q && stb) begin
      if (cnt_q == last_q) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= LONG_LAST;
      busy_q <= 1'b0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/sample_gate.sv
module sample_gate
  import adc_settle_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    stb,
  input  logic    force_zero,
  input  stereo_t din,
  output stereo_t dout
);
  stereo_t dout_q, dout_d;

  always_comb begin
    dout_d = force_zero ? '0 : din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dout_q <= '0;
    else if (stb) dout_q <= dout_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/adc_settle_gate.sv
module adc_settle_gate
  import adc_settle_pkg::*;
#(
  parameter int N_EN      = 4,
  parameter int LONG_CYC  = 1059,
  parameter int SHORT_CYC = 267
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EN-1:0]  pwr_en,
  input  logic             short_sel,
  input  logic             smp_stb,
  input  logic [SMP_W-1:0] smp_l,
  input  logic [SMP_W-1:0] smp_r,
  output logic [SMP_W-1:0] out_l,
  output logic [SMP_W-1:0] out_r,
  output logic             busy
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       start;
  stereo_t    din, dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  en_rise_detect #(.N_EN(N_EN)) u_edge (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .en   (pwr_en),
    .rise (start)
  );

  settle_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .short_sel(short_sel),
    .stb      (smp_stb),
    .busy     (busy)
  );

  assign din.l = smp_l;
  assign din.r = smp_r;

  sample_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .stb       (smp_stb),
    .force_zero(busy),
    .din       (din),
    .dout      (dout)
  );

  assign out_l = dout.l;
  assign out_r = dout.r;
endmodule

// File: rtl/adc_settle_gate_chk.sv
module adc_settle_gate_chk #(
  parameter int N_EN     = 4,
  parameter int SMP_W    = 24,
  parameter int LONG_CYC = 1059
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EN-1:0]  pwr_en,
  input logic             smp_stb,
  input logic [SMP_W-1:0] smp_l,
  input logic [SMP_W-1:0] smp_r,
  input logic [SMP_W-1:0] out_l,
  input logic [SMP_W-1:0] out_r,
  input logic             busy
);
  localparam int CW = $clog2(LONG_CYC + 2);
  logic [N_EN-1:0] en_p;
  logic [CW-1:0]   win_cnt;
  logic            rise_c;

  assign rise_c = |(pwr_en & ~en_p);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_p    <= '0;
      win_cnt <= '0;
    end else begin
      en_p <= pwr_en;
      if (rise_c)              win_cnt <= '0;
      else if (busy && smp_stb) win_cnt <= win_cnt + 1'b1;
    end
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_c |=> busy);

  assert_force_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && busy) |=> (out_l == '0 && out_r == '0));

  assert_pass_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !busy) |=> (out_l == $past(smp_l) && out_r == $past(smp_r)));

  assert_fall_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(smp_stb));

  assert_window_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (win_cnt < CW'(LONG_CYC)));
endmodule

bind adc_settle_gate adc_settle_gate_chk #(
  .N_EN    (N_EN),
  .SMP_W   (adc_settle_pkg::SMP_W),
  .LONG_CYC(LONG_CYC)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .pwr_en (pwr_en),
  .smp_stb(smp_stb),
  .smp_l  (smp_l),
  .smp_r  (smp_r),
  .out_l  (out_l),
  .out_r  (out_r),
  .busy   (busy)
);

// File: tb/test_adc_settle_gate.sv
`timescale 1ns/1ps
module test_adc_settle_gate;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   pwr_en;
  logic         short_sel;
  logic         smp_stb;
  logic [W-1:0] smp_l, smp_r;
  logic [W-1:0] out_l, out_r;
  logic         busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  adc_settle_gate i_adc_settle_gate (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .short_sel(short_sel),
    .smp_stb(smp_stb), .smp_l(smp_l), .smp_r(smp_r),
    .out_l(out_l), .out_r(out_r), .busy(busy)
  );

  localparam logic [2*W-1:0] VEC [6] = '{
    {24'h000001, 24'hFFFFFF},
    {24'h7FFFFF, 24'h800000},
    {24'h123456, 24'hABCDEF},
    {24'h000000, 24'h000000},
    {24'hFFFFFF, 24'h000001},
    {24'h5A5A5A, 24'hA5A5A5}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    smp_stb = 1'b1; smp_l = l; smp_r = r;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic set_en(input logic [3:0] v);
    @(negedge clk);
    pwr_en = v;
    @(negedge clk);
  endtask

  // Strobes until busy falls; every strobe must come out as zero.
  task automatic run_window(input int exp_len, input string req);
    int n = 0;
    int bad = 0;
    while (busy && n < 2000) begin
      strobe(24'h400000 + W'(n), 24'h300000 + W'(n));
      n++;
      if (out_l !== '0 || out_r !== '0) bad++;
    end
    check({"R7 zero during window ", req}, 64'(bad), 64'd0);
    check({req, " window length"}, 64'(n), 64'(exp_len));
  endtask

  initial begin
    rst_n = 1'b0; pwr_en = '0; short_sel = 1'b0; smp_stb = 1'b0;
    smp_l = '0; smp_r = '0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 64'(busy), 64'd0);
    check("R1 out in reset", {16'd0, out_l, out_r}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy after reset", 64'(busy), 64'd0);
    check("R1 out after reset", {16'd0, out_l, out_r}, 64'd0);

    // Vector table: pass-through with no starting edge (R8)
    for (int i = 0; i < 6; i++) begin
      strobe(VEC[i][2*W-1:W], VEC[i][W-1:0]);
      check("R8 pass vector", {16'd0, out_l, out_r}, {16'd0, VEC[i]});
    end
    repeat (3) @(negedge clk);
    check("R8 hold between strobes", {16'd0, out_l, out_r}, {16'd0, VEC[5]});

    // Long window on bit 0 (R2, R4, R9)
    short_sel = 1'b0;
    set_en(4'b0001);
    check("R2 busy after bit0 edge", 64'(busy), 64'd1);
    run_window(1059, "R4 R9");
    strobe(24'h111111, 24'h222222);
    check("R8 pass after window", {16'd0, out_l, out_r}, {16'd0, 24'h111111, 24'h222222});

    // Falling and steady enables start nothing (R3)
    set_en(4'b0000);
    check("R3 busy after fall", 64'(busy), 64'd0);
    strobe(24'h0ABCDE, 24'h0EDCBA);
    check("R3 pass after fall", {16'd0, out_l, out_r}, {16'd0, 24'h0ABCDE, 24'h0EDCBA});

    // Short window on bit 2, select toggled mid-window (R5, R6)
    short_sel = 1'b1;
    set_en(4'b0100);
    check("R2 busy after bit2 edge", 64'(busy), 64'd1);
    for (int i = 0; i < 10; i++) strobe(24'h1, 24'h2);
    short_sel = 1'b0;
    run_window(257, "R5 R6");
    set_en(4'b0100);
    check("R3 steady enable", 64'(busy), 64'd0);

    // Restart on bit 1 during window (R10)
    short_sel = 1'b1;
    set_en(4'b0000);
    set_en(4'b0001);
    for (int i = 0; i < 50; i++) strobe(24'h3, 24'h4);
    check("R10 still busy before restart", 64'(busy), 64'd1);
    set_en(4'b0011);
    run_window(267, "R10");

    // Edge and strobe in the same clock on bit 3 (R11)
    @(negedge clk);
    pwr_en = 4'b1011; smp_stb = 1'b1; smp_l = 24'h654321; smp_r = 24'h123456;
    @(negedge clk);
    smp_stb = 1'b0;
    check("R11 coincident strobe passes", {16'd0, out_l, out_r}, {16'd0, 24'h654321, 24'h123456});
    check("R11 busy set", 64'(busy), 64'd1);
    run_window(267, "R11");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule